// File: doc/BRIEF.md
# Channel Pair Startup Ramp Sequencer

This block sequences power-up and power-down for one pair of half-bridge legs in a four-leg class-D output stage. It watches the pair's active-low reset, a ramp-enable pin and a 3-bit output-mode code. From these it decides whether each leg is high impedance, ramping or switching. While ramping, it produces an 8-bit level code that an analog ramp generator turns into a slow move between ground and the half-supply bias point. Once switching, it routes the PWM inputs to the legs, inverting some of them when the mode asks for it.

The mode code is captured at each release of the pair reset. The ramp is used only in the all-half-bridge modes, and only when the ramp pin is high at that reset edge. A ramp in either direction can be reversed part-way and resumes from the level it had reached. The ramp advances one level per tick, and the tick comes from a clock divider whose period is a parameter. A fault request from the supervisor takes the pair straight to high impedance, with no ramp-down. After a fault, the pair stays idle until its reset is toggled.

Top module: `pair_ramp_seq`

## Requirements
- R1: After `rst`, both legs report high impedance (`leg_state` field 2'b00), `ramp_level` is 0 and `leg_drive` is 0. The pair leaves high impedance only on a low-to-high change of `pair_rst_n` seen after `rst`. A level held high since `rst` does not start it.
- R2: Ramp bypass applies when `ramp_en` is low at the reset edge, or when `cfg_code[1:0]` is not 2'b11. In bypass, the clock edge that sees `pair_rst_n` rise sets both legs to switching (2'b10). The edge that sees it low sets both legs to high impedance.
- R3: Ramp mode applies when `ramp_en` is high and `cfg_code` is 011 or 111. A release sets the legs to ramping (2'b01) with level 0. The level rises by one every RAMP_DIV clocks. The cycle after the level reaches 255, the legs switch, and the level holds at 255.
- R4: In ramp mode, a switching pair whose reset goes low enters ramping at level 255. The level falls by one every RAMP_DIV clocks. The cycle after the level reaches 0, the legs go to high impedance.
- R5: A reset change during a ramp reverses the ramp's direction at once, keeping the current level. The tick divider phase carries on across the reversal.
- R6: `cfg_code` is captured only on a reset release. Changes while the pair is out of reset have no effect on routing or sequencing.
- R7: Leg drive follows the captured code. Legs are numbered 0 to 3 globally, and this pair drives legs 2·PAIR_IDX and 2·PAIR_IDX+1 on `leg_drive[0]` and `leg_drive[1]`.
  - Codes 000, 001, 010, 011 and 111: leg g = in[g].
  - Code 100: even leg g = in[g], and odd leg g = ~in[g-1].
  - Code 101: legs 0 and 1 are straight, leg 2 = in[2] and leg 3 = ~in[2].
  - Code 110: even legs = in[0], and odd legs = ~in[0].
- R8: `fault_kill` high forces high impedance and level 0 on the next edge from any state, with no ramp-down. Afterwards the pair stays idle until `pair_rst_n` is seen rising again.
- R9: `leg_drive` is 0 on the cycle after any cycle in which the legs are not switching. Between two consecutive ramping cycles, the level moves by at most one step.
- R10: The cycle after `pair_rst_n` is seen low, the legs never report switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_rst_n | input | 1 | Active-low reset of this leg pair |
| ramp_en | input | 1 | Enables the mid-bias ramp; read at reset edges |
| cfg_code | input | 3 | Output-mode code, captured on reset release |
| fault_kill | input | 1 | Supervisor shutdown request |
| pwm_in | input | 4 | PWM inputs of all four legs |
| leg_state | output | 4 | Two 2-bit fields: 00 high impedance, 01 ramping, 10 switching |
| ramp_level | output | 8 | Ramp level code, 0 = ground, 255 = bias point |
| leg_drive | output | 2 | Routed PWM drive for the pair's two legs |

## Verification
Directed runs take each mode through a full ramp up, a full ramp down, and reversals at known levels. These separate level counting, tick phase and the end-of-ramp handoff. Every mode code is tried with several input patterns, which tells the straight, pair-inverted and single-source routings apart. A long constrained-random phase toggles reset, ramp enable, code and fault with random hold lengths. It is compared cycle by cycle with a bench model, which exposes reversal timing and fault priority against reset edges.

// File: rtl/pair_ramp_pkg.sv
package pair_ramp_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_RISE = 2'd1,
    PS_RUN  = 2'd2,
    PS_FALL = 2'd3
  } seq_state_e;

  localparam logic [1:0] LEG_HIZ  = 2'b00;
  localparam logic [1:0] LEG_RAMP = 2'b01;
  localparam logic [1:0] LEG_SW   = 2'b10;

  // all-half-bridge codes are the only ones that may ramp
  function automatic logic mode_half(input logic [2:0] code);
    return code[1:0] == 2'b11;
  endfunction

  function automatic logic [1:0] leg_code(input seq_state_e st);
    case (st)
      PS_RISE, PS_FALL: return LEG_RAMP;
      PS_RUN:           return LEG_SW;
      default:          return LEG_HIZ;
    endcase
  endfunction

  // drive of global leg g under the captured code
  function automatic logic route_leg(input logic [2:0] code,
                                     input logic [3:0] pwm,
                                     input int unsigned g);
    logic r;
    case (code)
      3'b100:  r = g[0] ? ~pwm[g-1] : pwm[g];
      3'b101:  r = (g < 2) ? pwm[g] : ((g == 2) ? pwm[2] : ~pwm[2]);
      3'b110:  r = g[0] ? ~pwm[0] : pwm[0];
      default: r = pwm[g];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ramp_tick.sv
module ramp_tick #(
  parameter int unsigned RAMP_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RAMP_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import pair_ramp_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_rst_n,
  input  logic             ramp_en,
  input  logic [2:0]       cfg_code,
  input  logic             fault_kill,
  input  logic             tick,
  output seq_state_e       st,
  output logic [LVL_W-1:0] lvl,
  output logic [2:0]       cfg_q,
  output logic             run
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  logic rn_q;
  logic rise;
  logic ramp_new;
  logic ramp_old;

  assign rise     = pair_rst_n && !rn_q;
  assign ramp_new = ramp_en && mode_half(cfg_code);
  assign ramp_old = ramp_en && mode_half(cfg_q);
  assign run      = (st == PS_RISE) || (st == PS_FALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PS_IDLE;
      lvl   <= '0;
      cfg_q <= '0;
      rn_q  <= 1'b1;
    end else begin
      rn_q <= pair_rst_n;
      if (fault_kill) begin
        st  <= PS_IDLE;
        lvl <= '0;
      end else begin
        case (st)
          PS_IDLE: begin
            if (rise) begin
              cfg_q <= cfg_code;
              lvl   <= '0;
              st    <= ramp_new ? PS_RISE : PS_RUN;
            end
          end
          PS_RISE: begin
            if (!pair_rst_n)         st  <= PS_FALL;
            else if (lvl == LVL_MAX) st  <= PS_RUN;
            else if (tick)           lvl <= lvl + 1'b1;
          end
          PS_RUN: begin
            if (!pair_rst_n) begin
              if (ramp_old) begin
                st  <= PS_FALL;
                lvl <= LVL_MAX;
              end else begin
                st  <= PS_IDLE;
                lvl <= '0;
              end
            end
          end
          PS_FALL: begin
            if (rise) begin
              cfg_q <= cfg_code;
              if (ramp_new) st <= PS_RISE;
              else begin
                st  <= PS_RUN;
                lvl <= '0;
              end
            end else if (lvl == '0) st  <= PS_IDLE;
            else if (tick)          lvl <= lvl - 1'b1;
          end
          default: st <= PS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/leg_router.sv
module leg_router
  import pair_ramp_pkg::*;
#(
  parameter int unsigned PAIR_IDX = 0,
  parameter int unsigned LEGS     = 2
) (
  input  logic [2:0]      cfg_q,
  input  logic [3:0]      pwm_in,
  output logic [LEGS-1:0] routed
);
  for (genvar j = 0; j < LEGS; j++) begin : g_leg
    localparam int unsigned GLEG = PAIR_IDX * LEGS + j;
    assign routed[j] = route_leg(cfg_q, pwm_in, GLEG);
  end
endmodule

// File: rtl/pair_ramp_seq.sv
module pair_ramp_seq
  import pair_ramp_pkg::*;
#(
  parameter int unsigned PAIR_IDX = 0,
  parameter int unsigned LVL_W    = 8,
  parameter int unsigned RAMP_DIV = 312500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_rst_n,
  input  logic             ramp_en,
  input  logic [2:0]       cfg_code,
  input  logic             fault_kill,
  input  logic [3:0]       pwm_in,
  output logic [3:0]       leg_state,
  output logic [LVL_W-1:0] ramp_level,
  output logic [1:0]       leg_drive
);
  localparam int unsigned LEGS = 2;

  seq_state_e       st;
  logic [LVL_W-1:0] lvl;
  logic [2:0]       cfg_q;
  logic             run;
  logic             tick;
  logic [LEGS-1:0]  routed;

  ramp_tick #(.RAMP_DIV(RAMP_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  ramp_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst(rst), .pair_rst_n(pair_rst_n), .ramp_en(ramp_en),
    .cfg_code(cfg_code), .fault_kill(fault_kill), .tick(tick),
    .st(st), .lvl(lvl), .cfg_q(cfg_q), .run(run)
  );

  leg_router #(.PAIR_IDX(PAIR_IDX), .LEGS(LEGS)) u_route (
    .cfg_q(cfg_q), .pwm_in(pwm_in), .routed(routed)
  );

  always_ff @(posedge clk) begin
    if (rst)               leg_drive <= '0;
    else if (st == PS_RUN) leg_drive <= routed;
    else                   leg_drive <= '0;
  end

  for (genvar j = 0; j < LEGS; j++) begin : g_state
    assign leg_state[2*j +: 2] = leg_code(st);
  end

  assign ramp_level = lvl;
endmodule

// File: rtl/pair_ramp_seq_chk.sv
module pair_ramp_seq_chk #(
  parameter int unsigned LVL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pair_rst_n,
  input logic             fault_kill,
  input logic [3:0]       leg_state,
  input logic [LVL_W-1:0] ramp_level,
  input logic [1:0]       leg_drive
);
  localparam logic [1:0] L_RAMP = 2'b01;
  localparam logic [1:0] L_SW   = 2'b10;

  assert_fault_hiz_R8: assert property (@(posedge clk) disable iff (rst)
    fault_kill |=> (leg_state == 4'b0000) && (ramp_level == '0));

  assert_drive_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (leg_state[1:0] != L_SW) |=> (leg_drive == 2'b00));

  assert_level_step_R9: assert property (@(posedge clk) disable iff (rst)
    (leg_state[1:0] == L_RAMP) |=> (leg_state[1:0] != L_RAMP)
      || (ramp_level == $past(ramp_level))
      || (ramp_level == $past(ramp_level) + 1'b1)
      || (ramp_level == $past(ramp_level) - 1'b1));

  assert_low_no_switch_R10: assert property (@(posedge clk) disable iff (rst)
    !pair_rst_n |=> (leg_state[1:0] != L_SW) && (leg_state[3:2] != L_SW));
endmodule

bind pair_ramp_seq pair_ramp_seq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .pair_rst_n(pair_rst_n), .fault_kill(fault_kill),
  .leg_state(leg_state), .ramp_level(ramp_level), .leg_drive(leg_drive)
);

// File: tb/sim_pair_ramp_seq.sv
module sim_pair_ramp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RDIV       = 4;
  localparam int PIDX       = 1;
  localparam int FULL       = 255 * RDIV + 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pair_rst_n = 1'b1;
  logic       ramp_en = 1'b0;
  logic [2:0] cfg_code = 3'b000;
  logic       fault_kill = 1'b0;
  logic [3:0] pwm_in = 4'b0000;
  logic [3:0] leg_state;
  logic [7:0] ramp_level;
  logic [1:0] leg_drive;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_ramp_seq #(.PAIR_IDX(PIDX), .LVL_W(8), .RAMP_DIV(RDIV)) u0 (
    .clk(clk), .rst(rst), .pair_rst_n(pair_rst_n), .ramp_en(ramp_en),
    .cfg_code(cfg_code), .fault_kill(fault_kill), .pwm_in(pwm_in),
    .leg_state(leg_state), .ramp_level(ramp_level), .leg_drive(leg_drive)
  );

  // expected drive of global leg g (R7)
  function automatic logic exp_leg(input logic [2:0] c, input logic [3:0] p, input int g);
    case (c)
      3'b100:  return (g % 2 == 1) ? ~p[g-1] : p[g];
      3'b101:  return (g < 2) ? p[g] : ((g == 2) ? p[2] : ~p[2]);
      3'b110:  return (g % 2 == 1) ? ~p[0] : p[0];
      default: return p[g];
    endcase
  endfunction

  function automatic logic [1:0] exp_drive(input logic [2:0] c, input logic [3:0] p);
    return {exp_leg(c, p, 2*PIDX+1), exp_leg(c, p, 2*PIDX)};
  endfunction

  // bench model from the requirements: 0 idle, 1 up, 2 switching, 3 down
  int         m_st = 0;
  int         m_lvl = 0;
  int         m_cnt = 0;
  logic [2:0] m_cfg = 3'b000;
  logic       m_rnq = 1'b1;
  logic [1:0] m_drv = 2'b00;

  function automatic logic [3:0] exp_state(input int s);
    logic [1:0] f;
    f = (s == 2) ? 2'b10 : ((s == 1 || s == 3) ? 2'b01 : 2'b00);
    return {f, f};
  endfunction

  always @(posedge clk) begin
    bit rise, tk, ramping, rnew, rold;
    if (rst) begin
      m_st = 0; m_lvl = 0; m_cnt = 0; m_cfg = 3'b000; m_rnq = 1'b1; m_drv = 2'b00;
    end else begin
      rise    = pair_rst_n && !m_rnq;
      ramping = (m_st == 1 || m_st == 3);
      tk      = ramping && (m_cnt == RDIV - 1);
      rnew    = ramp_en && (cfg_code[1:0] == 2'b11);
      rold    = ramp_en && (m_cfg[1:0] == 2'b11);
      m_drv   = (m_st == 2) ? exp_drive(m_cfg, pwm_in) : 2'b00;
      m_cnt   = (!ramping || tk) ? 0 : m_cnt + 1;
      m_rnq   = pair_rst_n;
      if (fault_kill) begin
        m_st = 0; m_lvl = 0;
      end else if (m_st == 0) begin
        if (rise) begin m_cfg = cfg_code; m_lvl = 0; m_st = rnew ? 1 : 2; end
      end else if (m_st == 1) begin
        if (!pair_rst_n) m_st = 3;
        else if (m_lvl == 255) m_st = 2;
        else if (tk) m_lvl++;
      end else if (m_st == 2) begin
        if (!pair_rst_n) begin
          if (rold) begin m_st = 3; m_lvl = 255; end
          else begin m_st = 0; m_lvl = 0; end
        end
      end else begin
        if (rise) begin
          m_cfg = cfg_code;
          if (rnew) m_st = 1; else begin m_st = 2; m_lvl = 0; end
        end else if (m_lvl == 0) m_st = 0;
        else if (tk) m_lvl--;
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (!rst) begin
      chk(tag, "model state", leg_state, exp_state(m_st));
      chk(tag, "model level", ramp_level, m_lvl);
      chk(tag, "model drive", leg_drive, m_drv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state, level held high since rst does not start the pair
    chk("R1", "state", leg_state, 0);
    chk("R1", "level", ramp_level, 0);
    chk("R1", "drive", leg_drive, 0);
    repeat (5) cyc();
    chk("R1", "no start without toggle", leg_state, 0);

    // R2 bypass release and assertion
    tag = "R2";
    pair_rst_n = 1'b0; cyc();
    pair_rst_n = 1'b1; cfg_code = 3'b000; pwm_in = 4'b0110; cyc();
    chk("R2", "bypass release switches", leg_state, 4'b1010);
    cyc();
    chk("R7", "straight drive", leg_drive, exp_drive(3'b000, 4'b0110));
    pair_rst_n = 1'b0; cyc();
    chk("R2", "bypass assertion hiz", leg_state, 0);
    chk("R10", "no switch while low", leg_state[1:0] != 2'b10, 1);

    // R3 full ramp up in quad half-bridge mode
    tag = "R3";
    cfg_code = 3'b011; ramp_en = 1'b1; pair_rst_n = 1'b1; cyc();
    chk("R3", "ramp start state", leg_state, 4'b0101);
    chk("R3", "ramp start level", ramp_level, 0);
    cyc();
    chk("R9", "no drive while ramping", leg_drive, 0);
    repeat (FULL) cyc();
    chk("R3", "switching after ramp", leg_state, 4'b1010);
    chk("R3", "level at bias", ramp_level, 255);

    // R4 ramp down, then R5 reversal
    tag = "R4";
    pair_rst_n = 1'b0; cyc();
    chk("R4", "down start", leg_state, 4'b0101);
    chk("R4", "down start level", ramp_level, 255);
    repeat (400) cyc();
    chk("R4", "down level", ramp_level, 155);
    tag = "R5";
    pair_rst_n = 1'b1; cyc();
    chk("R5", "reversal state", leg_state, 4'b0101);
    chk("R5", "reversal keeps level", ramp_level, 155);
    repeat (20) cyc();
    chk("R5", "climb after reversal", ramp_level, 160);
    repeat (FULL) cyc();
    chk("R5", "reaches switching", leg_state, 4'b1010);

    // R6 code changes while out of reset are ignored
    tag = "R6";
    cfg_code = 3'b110; pwm_in = 4'b0001; cyc(); cyc();
    chk("R6", "routing unchanged", leg_drive, exp_drive(3'b011, 4'b0001));

    // R4 down to idle
    tag = "R4";
    pair_rst_n = 1'b0; cfg_code = 3'b011;
    repeat (FULL) cyc();
    chk("R4", "idle after ramp down", leg_state, 0);
    chk("R4", "level at ground", ramp_level, 0);

    // R8 fault mid-ramp and latch until reset toggle
    tag = "R8";
    pair_rst_n = 1'b1; repeat (30) cyc();
    fault_kill = 1'b1; cyc();
    chk("R8", "fault hiz", leg_state, 0);
    chk("R8", "fault level", ramp_level, 0);
    fault_kill = 1'b0; repeat (6) cyc();
    chk("R8", "stays idle after fault", leg_state, 0);

    // R7 routing for every code with several patterns
    tag = "R7";
    ramp_en = 1'b0;
    for (int c = 0; c < 8; c++) begin
      pair_rst_n = 1'b0; cfg_code = 3'(c); cyc();
      pair_rst_n = 1'b1; cyc();
      for (int p = 0; p < 16; p += 3) begin
        pwm_in = 4'(p); cyc();
        chk("R7", $sformatf("code %0d drive", c), leg_drive, exp_drive(3'(c), 4'(p)));
      end
    end

    // random phase compared with the model every cycle
    tag = "R9";
    for (int k = 0; k < 60; k++) begin
      int hold;
      hold = 1 + ($urandom % 500);
      pair_rst_n = $urandom % 2;
      if ($urandom % 4 != 0) ramp_en = $urandom % 2;
      cfg_code = ($urandom % 2) ? 3'b011 : 3'($urandom);
      for (int h = 0; h < hold; h++) begin
        pwm_in = 4'($urandom);
        fault_kill = ($urandom % 300) == 0;
        cyc();
      end
      fault_kill = 1'b0;
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule